// File: doc/BRIEF.md
# Horizontal Microcode Sequencer with Opcode Dispatch

This block picks the address of the next microword for a horizontally microcoded stack processor. It keeps no running micro-program counter. Each microword names its own successor through a 2-bit next-address control field and a 10-bit target. A dispatch word sends control straight to the microword whose address equals the fetched opcode byte, so the lowest 256 microwords are opcode entry points. When an opcode needs more than one microword, its entry word is a plain jump to the rest of its routine. A word that targets its own address forms a single-word loop, and a condition ends that loop.

Each microword also chooses how long its own microcycle lasts. A 2-bit length field stretches the word over one, two or three base clocks. The microcode store sits outside the block. It is read combinationally at `uaddr`, and its 80-bit output comes back on `mword`. The `cycle_done` strobe marks the base clock in which the current word ends and `next_uaddr` is taken.

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is low, `uaddr` is 0x100 and `cycle_done` is 0. The reset takes effect at once, without waiting for a clock edge.
- R2: Microword field layout: bits [1:0] hold the next-address control, bits [11:2] the target, bits [13:12] the cycle length and bits [15:14] the condition select.
- R3: Control 00 (jump) moves `uaddr` to the target when the word ends.
- R4: Control 01 (dispatch) moves `uaddr` to the opcode byte, zero-extended to 10 bits. The target field is ignored.
- R5: Control 10 goes to the target if the selected flag is 1, and to `uaddr`+1 otherwise.
- R6: Control 11 goes to the target if the selected flag is 0, and to `uaddr`+1 otherwise.
- R7: Condition select 0, 1, 2 and 3 picks `flags` bit 0 (zero), bit 1 (negative), bit 2 (carry) and bit 3 (overflow).
- R8: A word lasts 1 base cycle for length code 0, 2 cycles for code 1, and 3 cycles for codes 2 and 3.
- R9: `cycle_done` is high only in the last cycle of a word, and `uaddr` does not change in the cycles before that.
- R10: The flags and the opcode are used only in the last cycle of a word. Their values in the earlier cycles have no effect.
- R11: A conditional word whose target is its own address repeats until its condition sends it on to `uaddr`+1.
- R12: The fall-through address wraps from 0x3FF to 0x000.
- R13: Microword bits [79:16] have no effect on sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| mword | input | 80 | Microword stored at `uaddr` |
| opcode | input | 8 | Byte opcode used by dispatch words |
| flags | input | 4 | ALU condition flags: zero, negative, carry, overflow (bits 0 to 3) |
| uaddr | output | 10 | Current microaddress |
| next_uaddr | output | 10 | Successor address; valid when `cycle_done` is high |
| cycle_done | output | 1 | High in the last base cycle of the current word |

## Verification
Two things meet in the same cycle: the word's length counter runs out, and the branch condition or opcode is sampled. A wrong design could sample the flags or the opcode in an earlier cycle of a stretched word. To provoke this, the bench changes the flags partway through a three-cycle conditional word, so the early and late values would branch differently. It then checks which successor appears in `uaddr` one edge after `cycle_done`. Self-loop words are checked the same way: `cycle_done` fires in every cycle while the address stays put, until the flag flips and the sequencer falls through.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // next-address control codes (bits [1:0] of every microword)
  typedef enum logic [1:0] {
    NX_JUMP     = 2'b00,
    NX_DISPATCH = 2'b01,
    NX_IF_TRUE  = 2'b10,
    NX_IF_FALSE = 2'b11
  } nxt_ctl_e;

  localparam int CTL_LSB = 0;
  localparam int CTL_W   = 2;
  localparam int CYC_W   = 2;
endpackage

// File: rtl/useq_field_dec.sv
module useq_field_dec
  import useq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 80,
  parameter int SEL_W  = 2
) (
  input  logic [WORD_W-1:0] mword,
  output nxt_ctl_e          ctl,
  output logic [ADDR_W-1:0] tgt,
  output logic [CYC_W-1:0]  cyc_len,
  output logic [SEL_W-1:0]  csel
);
  localparam int TGT_LSB  = CTL_LSB + CTL_W;
  localparam int CYC_LSB  = TGT_LSB + ADDR_W;
  localparam int CSEL_LSB = CYC_LSB + CYC_W;
  localparam int USED_W   = CSEL_LSB + SEL_W;

  always_comb begin
    ctl     = nxt_ctl_e'(mword[TGT_LSB-1:CTL_LSB]);
    tgt     = mword[CYC_LSB-1:TGT_LSB];
    cyc_len = mword[CSEL_LSB-1:CYC_LSB];
    csel    = mword[USED_W-1:CSEL_LSB];
  end

  // datapath control bits belong to other consumers
  logic unused_hi;
  assign unused_hi = ^mword[WORD_W-1:USED_W];
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel #(
  parameter int FLAG_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [SEL_W-1:0]  csel,
  output logic              cond
);
  always_comb begin
    cond = 1'b0;
    for (int i = 0; i < FLAG_W; i++) begin
      if (csel == SEL_W'(i)) cond = flags[i];
    end
  end
endmodule

// File: rtl/useq_stretch.sv
module useq_stretch
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CYC_W-1:0] cyc_len,
  output logic             cycle_done
);
  logic [1:0] wcnt_q, wcnt_d;
  logic [1:0] extra;

  always_comb begin
    unique case (cyc_len)
      2'd0:    extra = 2'd0;
      2'd1:    extra = 2'd1;
      default: extra = 2'd2;   // code 3 reserved, runs as slowest
    endcase
    cycle_done = en && (wcnt_q == extra);
    if (!en || cycle_done) wcnt_d = 2'd0;
    else                   wcnt_d = wcnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= 2'd0;
    else        wcnt_q <= wcnt_d;
  end

  // R8: no word is ever stretched beyond three base cycles
  a_r8_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q != 2'd3);
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OP_W   = 8
) (
  input  nxt_ctl_e          ctl,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [ADDR_W-1:0] uaddr,
  input  logic [OP_W-1:0]   opcode,
  input  logic              cond,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] entry;
  logic [ADDR_W-1:0] fall;

  generate
    if (ADDR_W > OP_W) begin : g_ext
      assign entry = {{(ADDR_W-OP_W){1'b0}}, opcode};
    end else begin : g_trunc
      assign entry = opcode[ADDR_W-1:0];
    end
  endgenerate

  assign fall = uaddr + ADDR_W'(1);

  always_comb begin
    unique case (ctl)
      NX_JUMP:     nxt = tgt;
      NX_DISPATCH: nxt = entry;
      NX_IF_TRUE:  nxt = cond  ? tgt : fall;
      NX_IF_FALSE: nxt = !cond ? tgt : fall;
      default:     nxt = tgt;
    endcase
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter int          WORD_W     = 80,
  parameter int          OP_W       = 8,
  parameter int          FLAG_W     = 4,
  parameter int unsigned RESET_ADDR = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mword,
  input  logic [OP_W-1:0]   opcode,
  input  logic [FLAG_W-1:0] flags,
  output logic [ADDR_W-1:0] uaddr,
  output logic [ADDR_W-1:0] next_uaddr,
  output logic              cycle_done
);
  localparam int SEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync_q;
  logic       run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  nxt_ctl_e          ctl;
  logic [ADDR_W-1:0] tgt;
  logic [CYC_W-1:0]  cyc_len;
  logic [SEL_W-1:0]  csel;
  logic              cond;
  logic              done;
  logic [ADDR_W-1:0] uaddr_q, uaddr_d;

  useq_field_dec #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) dec_i (
    .mword(mword), .ctl(ctl), .tgt(tgt), .cyc_len(cyc_len), .csel(csel)
  );

  useq_cond_sel #(.FLAG_W(FLAG_W), .SEL_W(SEL_W)) cond_i (
    .flags(flags), .csel(csel), .cond(cond)
  );

  useq_stretch stretch_i (
    .clk(clk), .rst_n(run), .en(run), .cyc_len(cyc_len), .cycle_done(done)
  );

  useq_next_addr #(.ADDR_W(ADDR_W), .OP_W(OP_W)) nxt_i (
    .ctl(ctl), .tgt(tgt), .uaddr(uaddr_q), .opcode(opcode), .cond(cond),
    .nxt(next_uaddr)
  );

  always_comb begin
    uaddr_d = uaddr_q;
    if (done) uaddr_d = next_uaddr;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) uaddr_q <= ADDR_W'(RESET_ADDR);
    else      uaddr_q <= uaddr_d;
  end

  assign uaddr      = uaddr_q;
  assign cycle_done = done;

  // R3: a jump word lands on its target
  a_r3_jump_target: assert property (@(posedge clk) disable iff (!run)
    (done && ctl == NX_JUMP) |=> uaddr_q == $past(tgt));

  // R4: dispatch lands on the opcode value
  a_r4_dispatch: assert property (@(posedge clk) disable iff (!run)
    (done && ctl == NX_DISPATCH) |=> uaddr_q == ADDR_W'($past(opcode)));

  // R5: untaken if-true branch falls to the following word
  a_r5_fall_through: assert property (@(posedge clk) disable iff (!run)
    (done && ctl == NX_IF_TRUE && !cond) |=> uaddr_q == ADDR_W'($past(uaddr_q) + 1'b1));

  // R9: the address holds while a word is being stretched
  a_r9_hold_in_wait: assert property (@(posedge clk) disable iff (!run)
    !done |=> $stable(uaddr_q));

  // R8: a length-0 word always ends in its first cycle
  a_r8_fast_word: assert property (@(posedge clk) disable iff (!run)
    (cyc_len == 2'd0) |-> done);
endmodule

// File: tb/useq_core_tb_top.sv
`timescale 1ns/1ps
module useq_core_tb_top;
  logic        clk;
  logic        rst_n;
  logic [79:0] mword;
  logic [7:0]  opcode;
  logic [3:0]  flags;
  logic [9:0]  uaddr;
  logic [9:0]  next_uaddr;
  logic        cycle_done;

  logic [79:0] rom [1024];
  assign mword = rom[uaddr];

  int checks = 0;
  int errors = 0;
  bit done_all = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  useq_core dut_i (
    .clk(clk), .rst_n(rst_n), .mword(mword), .opcode(opcode), .flags(flags),
    .uaddr(uaddr), .next_uaddr(next_uaddr), .cycle_done(cycle_done)
  );

  typedef struct packed {
    logic [1:0] ctl;
    logic [9:0] tgt;
    logic [1:0] cyc;
    logic [1:0] csel;
    logic [7:0] op;
    logic [3:0] fl;
    logic [9:0] start;
    logic [9:0] exp;
    logic [1:0] ncyc;
    logic       junk;
    logic [3:0] req;
  } vec_t;

  // field layout per R2: {hi, csel, cyc, tgt, ctl}
  localparam vec_t VECS [16] = '{
    '{2'd0, 10'h2A5, 2'd0, 2'd0, 8'h00, 4'h0, 10'h010, 10'h2A5, 2'd1, 1'b0, 4'd3},  // R3
    '{2'd0, 10'h155, 2'd1, 2'd0, 8'h00, 4'h0, 10'h011, 10'h155, 2'd2, 1'b0, 4'd8},  // R8
    '{2'd0, 10'h3F0, 2'd2, 2'd0, 8'h00, 4'h0, 10'h012, 10'h3F0, 2'd3, 1'b0, 4'd8},  // R8
    '{2'd0, 10'h001, 2'd3, 2'd0, 8'h00, 4'h0, 10'h013, 10'h001, 2'd3, 1'b0, 4'd8},  // R8 reserved code
    '{2'd1, 10'h3FF, 2'd0, 2'd0, 8'hC3, 4'h0, 10'h200, 10'h0C3, 2'd1, 1'b0, 4'd4},  // R4
    '{2'd1, 10'h2AA, 2'd2, 2'd0, 8'h00, 4'h0, 10'h201, 10'h000, 2'd3, 1'b0, 4'd4},  // R4
    '{2'd2, 10'h0AB, 2'd0, 2'd0, 8'h00, 4'h1, 10'h040, 10'h0AB, 2'd1, 1'b0, 4'd5},  // R5
    '{2'd2, 10'h0AB, 2'd0, 2'd0, 8'h00, 4'hE, 10'h041, 10'h042, 2'd1, 1'b0, 4'd5},  // R5
    '{2'd3, 10'h0CD, 2'd1, 2'd0, 8'h00, 4'h0, 10'h050, 10'h0CD, 2'd2, 1'b0, 4'd6},  // R6
    '{2'd3, 10'h0CD, 2'd1, 2'd0, 8'h00, 4'h1, 10'h051, 10'h052, 2'd2, 1'b0, 4'd6},  // R6
    '{2'd2, 10'h111, 2'd0, 2'd1, 8'h00, 4'h2, 10'h060, 10'h111, 2'd1, 1'b0, 4'd7},  // R7 negative
    '{2'd2, 10'h122, 2'd0, 2'd2, 8'h00, 4'h4, 10'h061, 10'h122, 2'd1, 1'b0, 4'd7},  // R7 carry
    '{2'd2, 10'h133, 2'd0, 2'd3, 8'h00, 4'h7, 10'h062, 10'h063, 2'd1, 1'b0, 4'd7},  // R7 overflow clear
    '{2'd3, 10'h144, 2'd0, 2'd3, 8'h00, 4'h8, 10'h063, 10'h064, 2'd1, 1'b0, 4'd7},  // R7 overflow set
    '{2'd3, 10'h155, 2'd0, 2'd0, 8'h00, 4'h1, 10'h3FF, 10'h000, 2'd1, 1'b0, 4'd12}, // R12 wrap
    '{2'd0, 10'h0EE, 2'd0, 2'd0, 8'h00, 4'h0, 10'h070, 10'h0EE, 2'd1, 1'b1, 4'd13}  // R13
  };

  function automatic logic [79:0] mk(logic [1:0] ctl, logic [9:0] tgt,
                                     logic [1:0] cyc, logic [1:0] csel, logic junk);
    return {(junk ? {64{1'b1}} : 64'h0), csel, cyc, tgt, ctl};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reset, point the fetch word at start, wait until start is current
  task automatic launch(logic [9:0] start, logic [79:0] word,
                        logic [7:0] op, logic [3:0] fl);
    rst_n = 1'b0;
    rom[10'h100] = mk(2'd0, start, 2'd0, 2'd0, 1'b0);
    rom[start]   = word;
    opcode = op;
    flags  = fl;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10 && uaddr != start; i++) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done_all) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) rom[i] = '0;
    rst_n = 1'b0; opcode = '0; flags = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(uaddr == 10'h100, "R1 reset address", uaddr, 10'h100);
    chk(cycle_done == 1'b0, "R1 no strobe in reset", cycle_done, 0);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R12 R13
    for (int v = 0; v < 16; v++) begin
      int n;
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[v].req, v);
      launch(VECS[v].start,
             mk(VECS[v].ctl, VECS[v].tgt, VECS[v].cyc, VECS[v].csel, VECS[v].junk),
             VECS[v].op, VECS[v].fl);
      chk(uaddr == VECS[v].start, {tg, " reach start"}, uaddr, VECS[v].start);
      n = 1;
      for (int k = 0; k < 5 && !cycle_done; k++) begin
        @(negedge clk);
        n++;
        chk(uaddr == VECS[v].start, {tg, " R9 hold"}, uaddr, VECS[v].start);
      end
      chk(n == int'(VECS[v].ncyc), {tg, " cycle count"}, n, VECS[v].ncyc);
      chk(next_uaddr == VECS[v].exp, {tg, " next_uaddr"}, next_uaddr, VECS[v].exp);
      @(negedge clk);
      chk(uaddr == VECS[v].exp, {tg, " uaddr after"}, uaddr, VECS[v].exp);
    end

    // R10: flag true early, false in the last cycle -> falls through
    launch(10'h020, mk(2'd2, 10'h2F0, 2'd2, 2'd0, 1'b0), 8'h00, 4'h1);
    chk(cycle_done == 1'b0, "R9 strobe low cycle1", cycle_done, 0);
    @(negedge clk);
    flags = 4'h0;
    chk(cycle_done == 1'b0, "R9 strobe low cycle2", cycle_done, 0);
    @(negedge clk);
    chk(cycle_done == 1'b1, "R9 strobe in last cycle", cycle_done, 1);
    @(negedge clk);
    chk(uaddr == 10'h021, "R10 late flag used", uaddr, 10'h021);

    // R10: opcode changes during a stretched dispatch word
    launch(10'h022, mk(2'd1, 10'h000, 2'd2, 2'd0, 1'b0), 8'h11, 4'h0);
    @(negedge clk);
    opcode = 8'h7E;
    repeat (2) @(negedge clk);
    chk(uaddr == 10'h07E, "R10 late opcode used", uaddr, 10'h07E);

    // R11: self loop until zero flag rises
    launch(10'h030, mk(2'd3, 10'h030, 2'd0, 2'd0, 1'b0), 8'h00, 4'h0);
    for (int k = 0; k < 4; k++) begin
      chk(uaddr == 10'h030 && cycle_done, "R11 loop stays", uaddr, 10'h030);
      @(negedge clk);
    end
    flags = 4'h1;
    @(negedge clk);
    chk(uaddr == 10'h031, "R11 loop exit", uaddr, 10'h031);

    // R1: asynchronous effect mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(uaddr == 10'h100, "R1 async reset", uaddr, 10'h100);
    chk(cycle_done == 1'b0, "R1 strobe cleared", cycle_done, 0);

    done_all = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule